// File: doc/BRIEF.md
# I2C Slave Event Status Register

This block collects the events reported by an I2C slave protocol engine and keeps them as sticky status flags until software acknowledges them. The engine sends single-cycle strobes: start, repeated start, stop, address match together with the index of the slave ID that matched, general call with its kind, receive-FIFO write and overflow, transmit-FIFO underflow and not-full, end of transmission, no-ACK, and a level busy signal. The register-bus side sends single-cycle strobes for a status read, a status write, a receive-data read, a transmit-data write, a FIFO flush and the configuration bit that clears the general call flag. Each flag clears only on its own condition.

A small transaction tracker decides when an address match counts. Its states are `TRK_IDLE`, `TRK_WAIT_S` (start seen, address pending), `TRK_WAIT_R` (repeated start seen, address pending) and `TRK_MATCHED` (address matched). Transitions: any state goes to `TRK_WAIT_S` on start and to `TRK_WAIT_R` on repeated start (start has priority). A stop returns any state to `TRK_IDLE`. `TRK_WAIT_S` and `TRK_WAIT_R` go to `TRK_MATCHED` on a match. A general call reset forces `TRK_IDLE`. A second tracker counts transmit-data writes for the not-full flag. It moves from `NF_ARMED` to `NF_ONE_WR` on a write while the flag is set. It returns to `NF_ARMED` on the next write, and that write clears the flag. A new not-full event or a general call reset also sends it back to `NF_ARMED`.

The combined interrupt is the OR of every sticky flag whose enable bit is set.

Top module: `i2c_slv_evt_status`

## Requirements
- R1: After reset, `status` and `irq` are all zero.
- R2: Start-decode (status bit 0) is set when an address match arrives in `TRK_WAIT_S`. It is cleared by a stop or by a general call reset.
- R3: Repeated-start-decode (bit 1) is set when an address match arrives in `TRK_WAIT_R`. It is cleared by a stop, a status read or a general call reset.
- R4: Bits 12:11 hold the matched ID index (00 to 11 for IDs 0 to 3). The field loads only on a match that sets bit 0 or bit 1. A match in `TRK_IDLE` or `TRK_MATCHED`, or in the same cycle as a stop, is ignored.
- R5: Stop-after-start (bit 2) is set by a stop that arrives in `TRK_MATCHED`. A stop in any other state leaves it clear. A status read clears it.
- R6: A general call with a nonzero kind sets the general call flag (bit 3) and loads the kind into bits 14:13. The kinds are 01 reset and program address, 10 program address, 11 alternative ID match. A strobe with kind 00 is ignored. `cfg_gc_clr` clears bit 3 and bits 14:13.
- R7: A general call of kind 01 clears every other flag, clears the ID field and returns both trackers to their first state. It still records bit 3 and kind 01.
- R8: No-ACK (bit 4) and receive overflow (bit 5) are set by their strobes. Both are cleared by a status read.
- R9: Receive IRQ (bit 6) is set by a receive-FIFO write. It is cleared by a receive-data read or a FIFO flush.
- R10: Transmit IRQ (bit 7) is set at end of transmission and cleared by a transmit-data write. Transmit underflow (bit 8) is cleared by a status write.
- R11: Transmit-not-full (bit 9) is set by its strobe. The first transmit-data write after that leaves it set, and the second write clears it.
- R12: When a set and a clear reach the same flag in the same cycle, the flag ends set.
- R13: Bit 10 follows `eng_busy` in the same cycle without latching. Bits 31:15 always read zero.
- R14: `irq` is high exactly when some flag bit i (bits 9:0) is set together with `irq_en[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Engine: start condition |
| ev_rstart | input | 1 | Engine: repeated start condition |
| ev_stop | input | 1 | Engine: stop condition |
| ev_addr_match | input | 1 | Engine: received address matched an ID |
| ev_match_id | input | 2 | Engine: index of the matched ID |
| ev_gc | input | 1 | Engine: general call received |
| ev_gc_kind | input | 2 | Engine: general call kind |
| ev_rx_wr | input | 1 | Engine: byte written to receive FIFO |
| ev_rx_ovf | input | 1 | Engine: receive FIFO overflow |
| ev_tx_undf | input | 1 | Engine: transmit FIFO underflow |
| ev_tx_nfull | input | 1 | Engine: transmit FIFO not full |
| ev_tx_done | input | 1 | Engine: end of transmission |
| ev_nack | input | 1 | Engine: data requested, none available |
| eng_busy | input | 1 | Engine busy level |
| bus_st_rd | input | 1 | Bus: status register read |
| bus_st_wr | input | 1 | Bus: status register write |
| bus_rx_rd | input | 1 | Bus: receive data read |
| bus_tx_wr | input | 1 | Bus: transmit data write |
| bus_fifo_flush | input | 1 | Bus: FIFO flush |
| cfg_gc_clr | input | 1 | Bus: general call flag clear bit written |
| irq_en | input | 10 | Per-flag interrupt enable, bit i for status bit i |
| status | output | 32 | Status word |
| irq | output | 1 | Combined interrupt |

## Verification
The checker watches several behaviours on every cycle. A stop clears both decode flags. A status read clears no-ACK and overflow unless a set arrives in the same cycle. The receive IRQ follows its set and its clear. A valid general call loads its kind. The reserved bits stay zero, and the interrupt stays low while all enables are off. Other behaviours depend on a sequence of events, and only the bench's scenarios can show them. These are the tracker's decision that a match counts and which decode flag it sets, stop-after-start only after a matched start, the two-write clear of transmit-not-full, the wide clear of a general call reset, and set-wins on each flag.

// File: rtl/slv_evt_pkg.sv
package slv_evt_pkg;
    localparam int NFLAG    = 10;
    localparam int ID_W     = 2;
    localparam int GCK_W    = 2;

    // sticky flag positions, also their status bit and irq_en bit
    localparam int F_START  = 0;
    localparam int F_RSTART = 1;
    localparam int F_STOPAS = 2;
    localparam int F_GC     = 3;
    localparam int F_NACK   = 4;
    localparam int F_RXOVF  = 5;
    localparam int F_RXIRQ  = 6;
    localparam int F_TXIRQ  = 7;
    localparam int F_TXUNDF = 8;
    localparam int F_TXNF   = 9;

    localparam int B_BUSY   = NFLAG;
    localparam int B_ID_LO  = B_BUSY + 1;
    localparam int B_GC_LO  = B_ID_LO + ID_W;
    localparam int B_USED   = B_GC_LO + GCK_W;

    localparam logic [GCK_W-1:0] GC_NONE  = 2'b00;
    localparam logic [GCK_W-1:0] GC_RESET = 2'b01;

    typedef enum logic [1:0] {
        TRK_IDLE,
        TRK_WAIT_S,
        TRK_WAIT_R,
        TRK_MATCHED
    } trk_state_e;

    typedef enum logic {
        NF_ARMED,
        NF_ONE_WR
    } nf_state_e;
endpackage

// File: rtl/slv_txn_tracker.sv
module slv_txn_tracker
    import slv_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gc_rst,
    input  logic ev_start,
    input  logic ev_rstart,
    input  logic ev_stop,
    input  logic ev_match,
    output logic set_start,
    output logic set_rstart,
    output logic set_stopas,
    output logic id_load
);
    trk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        set_start  = 1'b0;
        set_rstart = 1'b0;
        set_stopas = 1'b0;
        id_load    = 1'b0;
        if (gc_rst) begin
            state_d = TRK_IDLE;
        end else if (ev_start) begin
            state_d = TRK_WAIT_S;
        end else if (ev_rstart) begin
            state_d = TRK_WAIT_R;
        end else if (ev_stop) begin
            state_d    = TRK_IDLE;
            set_stopas = (state_q == TRK_MATCHED);
        end else begin
            unique case (state_q)
                TRK_IDLE: begin
                    state_d = TRK_IDLE;
                end
                TRK_WAIT_S: begin
                    if (ev_match) begin
                        state_d   = TRK_MATCHED;
                        set_start = 1'b1;
                        id_load   = 1'b1;
                    end
                end
                TRK_WAIT_R: begin
                    if (ev_match) begin
                        state_d    = TRK_MATCHED;
                        set_rstart = 1'b1;
                        id_load    = 1'b1;
                    end
                end
                TRK_MATCHED: begin
                    state_d = TRK_MATCHED;
                end
                default: state_d = TRK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slv_txnf_gate.sv
module slv_txnf_gate
    import slv_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gc_rst,
    input  logic nf_set,
    input  logic nf_flag,
    input  logic tx_wr,
    output logic nf_clr
);
    nf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NF_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        nf_clr  = 1'b0;
        if (gc_rst || nf_set) begin
            state_d = NF_ARMED;
        end else begin
            unique case (state_q)
                NF_ARMED: begin
                    if (tx_wr && nf_flag) state_d = NF_ONE_WR;
                end
                NF_ONE_WR: begin
                    if (tx_wr) begin
                        state_d = NF_ARMED;
                        nf_clr  = 1'b1;
                    end
                end
                default: state_d = NF_ARMED;
            endcase
        end
    end
endmodule

// File: rtl/slv_flag_bank.sv
module slv_flag_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (set_v[i])
                flag_q[i] <= 1'b1;
            else if (clr_v[i] || wipe)
                flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_slv_evt_status.sv
module i2c_slv_evt_status
    import slv_evt_pkg::*;
#(
    parameter int STATUS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_start,
    input  logic                ev_rstart,
    input  logic                ev_stop,
    input  logic                ev_addr_match,
    input  logic [ID_W-1:0]     ev_match_id,
    input  logic                ev_gc,
    input  logic [GCK_W-1:0]    ev_gc_kind,
    input  logic                ev_rx_wr,
    input  logic                ev_rx_ovf,
    input  logic                ev_tx_undf,
    input  logic                ev_tx_nfull,
    input  logic                ev_tx_done,
    input  logic                ev_nack,
    input  logic                eng_busy,
    input  logic                bus_st_rd,
    input  logic                bus_st_wr,
    input  logic                bus_rx_rd,
    input  logic                bus_tx_wr,
    input  logic                bus_fifo_flush,
    input  logic                cfg_gc_clr,
    input  logic [NFLAG-1:0]    irq_en,
    output logic [STATUS_W-1:0] status,
    output logic                irq
);
    logic gc_valid, gc_rst;
    logic set_start, set_rstart, set_stopas, id_load, nf_clr;
    logic [NFLAG-1:0] set_v, clr_v, flags;
    logic [ID_W-1:0]  id_q;
    logic [GCK_W-1:0] gck_q;

    assign gc_valid = ev_gc && (ev_gc_kind != GC_NONE);
    assign gc_rst   = ev_gc && (ev_gc_kind == GC_RESET);

    slv_txn_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .gc_rst    (gc_rst),
        .ev_start  (ev_start),
        .ev_rstart (ev_rstart),
        .ev_stop   (ev_stop),
        .ev_match  (ev_addr_match),
        .set_start (set_start),
        .set_rstart(set_rstart),
        .set_stopas(set_stopas),
        .id_load   (id_load)
    );

    slv_txnf_gate u_nf (
        .clk    (clk),
        .rst_n  (rst_n),
        .gc_rst (gc_rst),
        .nf_set (ev_tx_nfull),
        .nf_flag(flags[F_TXNF]),
        .tx_wr  (bus_tx_wr),
        .nf_clr (nf_clr)
    );

    always_comb begin
        set_v           = '0;
        set_v[F_START]  = set_start;
        set_v[F_RSTART] = set_rstart;
        set_v[F_STOPAS] = set_stopas;
        set_v[F_GC]     = gc_valid;
        set_v[F_NACK]   = ev_nack;
        set_v[F_RXOVF]  = ev_rx_ovf;
        set_v[F_RXIRQ]  = ev_rx_wr;
        set_v[F_TXIRQ]  = ev_tx_done;
        set_v[F_TXUNDF] = ev_tx_undf;
        set_v[F_TXNF]   = ev_tx_nfull;

        clr_v           = '0;
        clr_v[F_START]  = ev_stop;
        clr_v[F_RSTART] = ev_stop || bus_st_rd;
        clr_v[F_STOPAS] = bus_st_rd;
        clr_v[F_GC]     = cfg_gc_clr;
        clr_v[F_NACK]   = bus_st_rd;
        clr_v[F_RXOVF]  = bus_st_rd;
        clr_v[F_RXIRQ]  = bus_rx_rd || bus_fifo_flush;
        clr_v[F_TXIRQ]  = bus_tx_wr;
        clr_v[F_TXUNDF] = bus_st_wr;
        clr_v[F_TXNF]   = nf_clr;
    end

    slv_flag_bank #(.N(NFLAG)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (gc_rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .flag_q(flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       id_q <= '0;
        else if (id_load) id_q <= ev_match_id;
        else if (gc_rst)  id_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gck_q <= GC_NONE;
        else if (gc_valid)   gck_q <= ev_gc_kind;
        else if (cfg_gc_clr) gck_q <= GC_NONE;
    end

    always_comb begin
        status                      = '0;
        status[NFLAG-1:0]           = flags;
        status[B_BUSY]              = eng_busy;
        status[B_ID_LO +: ID_W]     = id_q;
        status[B_GC_LO +: GCK_W]    = gck_q;
    end

    assign irq = |(flags & irq_en);
endmodule

// File: rtl/chk_slv_evt_status.sv
module chk_slv_evt_status
    import slv_evt_pkg::*;
#(
    parameter int STATUS_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ev_stop,
    input logic                ev_gc,
    input logic [GCK_W-1:0]    ev_gc_kind,
    input logic                ev_rx_wr,
    input logic                ev_rx_ovf,
    input logic                ev_nack,
    input logic                bus_st_rd,
    input logic                bus_rx_rd,
    input logic [NFLAG-1:0]    irq_en,
    input logic [STATUS_W-1:0] status,
    input logic                irq
);
    a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!status[F_START] && !status[F_RSTART]));

    a_r8_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st_rd && !ev_nack && !ev_rx_ovf) |=> (!status[F_NACK] && !status[F_RXOVF]));

    a_r9_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_wr |=> status[F_RXIRQ]);

    a_r9_rx_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rx_rd && !ev_rx_wr) |=> !status[F_RXIRQ]);

    a_r6_gc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_gc && ev_gc_kind != GC_NONE) |=>
            (status[F_GC] && status[B_GC_LO +: GCK_W] == $past(ev_gc_kind)));

    a_r13_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        status[STATUS_W-1:B_USED] == '0);

    a_r14_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
endmodule

bind i2c_slv_evt_status chk_slv_evt_status #(.STATUS_W(STATUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_stop   (ev_stop),
    .ev_gc     (ev_gc),
    .ev_gc_kind(ev_gc_kind),
    .ev_rx_wr  (ev_rx_wr),
    .ev_rx_ovf (ev_rx_ovf),
    .ev_nack   (ev_nack),
    .bus_st_rd (bus_st_rd),
    .bus_rx_rd (bus_rx_rd),
    .irq_en    (irq_en),
    .status    (status),
    .irq       (irq)
);

// File: tb/sim_i2c_slv_evt_status.sv
`timescale 1ns/1ps
module sim_i2c_slv_evt_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_addr_match = 0;
    logic [1:0] ev_match_id = '0;
    logic ev_gc = 0;
    logic [1:0] ev_gc_kind = '0;
    logic ev_rx_wr = 0, ev_rx_ovf = 0, ev_tx_undf = 0, ev_tx_nfull = 0;
    logic ev_tx_done = 0, ev_nack = 0, eng_busy = 0;
    logic bus_st_rd = 0, bus_st_wr = 0, bus_rx_rd = 0, bus_tx_wr = 0;
    logic bus_fifo_flush = 0, cfg_gc_clr = 0;
    logic [9:0] irq_en = '0;
    logic [31:0] status;
    logic irq;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    i2c_slv_evt_status u0 (.*);

    // stimulus bits: 0 start,1 rstart,2 stop,3 match,4 rx_wr,5 rx_ovf,6 nack,
    // 7 tx_done,8 tx_undf,9 tx_nfull,10 st_rd,11 st_wr,12 rx_rd,13 tx_wr,
    // 14 flush,15 gc_clr. Entry: {stim16, id_in2, exp_id2, exp_flags10}
    localparam logic [29:0] VEC [0:23] = '{
        {16'h0001, 2'd0, 2'd0, 10'h000},  // start
        {16'h0008, 2'd2, 2'd2, 10'h001},  // R2 match after start
        {16'h0010, 2'd0, 2'd2, 10'h041},  // R9 rx write
        {16'h1000, 2'd0, 2'd2, 10'h001},  // R9 rx read
        {16'h0002, 2'd0, 2'd2, 10'h001},  // repeated start
        {16'h0008, 2'd3, 2'd3, 10'h003},  // R3 R4 match after rstart
        {16'h0400, 2'd0, 2'd3, 10'h001},  // R3 status read
        {16'h0004, 2'd0, 2'd3, 10'h004},  // R5 R2 stop after match
        {16'h0400, 2'd0, 2'd3, 10'h000},  // R5 status read
        {16'h0060, 2'd0, 2'd3, 10'h030},  // R8 nack + ovf
        {16'h0440, 2'd0, 2'd3, 10'h010},  // R12 read with nack
        {16'h0400, 2'd0, 2'd3, 10'h000},  // R8 read
        {16'h0180, 2'd0, 2'd3, 10'h180},  // R10 tx done + undf
        {16'h0800, 2'd0, 2'd3, 10'h080},  // R10 status write
        {16'h2000, 2'd0, 2'd3, 10'h000},  // R10 tx write
        {16'h0200, 2'd0, 2'd3, 10'h200},  // R11 not full
        {16'h2000, 2'd0, 2'd3, 10'h200},  // R11 first write
        {16'h2000, 2'd0, 2'd3, 10'h000},  // R11 second write
        {16'h0010, 2'd0, 2'd3, 10'h040},  // rx write
        {16'h4000, 2'd0, 2'd3, 10'h000},  // R9 flush
        {16'h0004, 2'd0, 2'd3, 10'h000},  // R5 stop, idle
        {16'h0008, 2'd1, 2'd3, 10'h000},  // R4 match in idle ignored
        {16'h1010, 2'd0, 2'd3, 10'h040},  // R12 rx write + read
        {16'h1000, 2'd0, 2'd3, 10'h000}   // R9 read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] s, input logic [1:0] id);
        ev_start = s[0]; ev_rstart = s[1]; ev_stop = s[2]; ev_addr_match = s[3];
        ev_rx_wr = s[4]; ev_rx_ovf = s[5]; ev_nack = s[6]; ev_tx_done = s[7];
        ev_tx_undf = s[8]; ev_tx_nfull = s[9]; bus_st_rd = s[10]; bus_st_wr = s[11];
        bus_rx_rd = s[12]; bus_tx_wr = s[13]; bus_fifo_flush = s[14]; cfg_gc_clr = s[15];
        ev_match_id = id;
    endtask

    task automatic step(input logic [15:0] s, input logic [1:0] id);
        drive(s, id);
        @(posedge clk);
        #1;
        drive(16'h0000, 2'd0);
        ev_gc = 1'b0;
        ev_gc_kind = 2'd0;
    endtask

    task automatic gc_step(input logic [1:0] kind, input logic [15:0] s);
        ev_gc = 1'b1;
        ev_gc_kind = kind;
        step(s, 2'd0);
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1;
        check("R1 status", status, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 status after release", status, 32'h0);

        for (int i = 0; i < 24; i++) begin
            step(VEC[i][29:14], VEC[i][13:12]);
            check($sformatf("R2-table flags v%0d", i), {22'h0, status[9:0]}, {22'h0, VEC[i][9:0]});
            check($sformatf("R4 id v%0d", i), {30'h0, status[12:11]}, {30'h0, VEC[i][11:10]});
        end

        // R13 busy mirror and reserved bits
        eng_busy = 1'b1;
        #1;
        check("R13 busy high", {31'h0, status[10]}, 32'h1);
        check("R13 reserved", {15'h0, status[31:15]}, 32'h0);
        eng_busy = 1'b0;
        #1;
        check("R13 busy low", {31'h0, status[10]}, 32'h0);

        // R14 interrupt mask
        step(16'h0010, 2'd0);
        irq_en = 10'h040;
        #1;
        check("R14 enabled", {31'h0, irq}, 32'h1);
        irq_en = 10'h3BF;
        #1;
        check("R14 masked", {31'h0, irq}, 32'h0);
        irq_en = 10'h000;
        step(16'h1000, 2'd0);

        // R5 stop after unmatched start
        step(16'h0001, 2'd0);
        step(16'h0004, 2'd0);
        check("R5 no match stop", {22'h0, status[9:0]}, 32'h0);

        // R11 set wins over second write, counter restarts
        step(16'h0200, 2'd0);
        step(16'h2000, 2'd0);
        step(16'h2200, 2'd0);
        check("R12 R11 set wins", {31'h0, status[9]}, 32'h1);
        step(16'h2000, 2'd0);
        check("R11 first write again", {31'h0, status[9]}, 32'h1);
        step(16'h2000, 2'd0);
        check("R11 cleared", {31'h0, status[9]}, 32'h0);

        // R6 general call kinds
        gc_step(2'b10, 16'h0000);
        check("R6 gc kind 10", status, 32'h0000_5808);
        gc_step(2'b00, 16'h0000);
        check("R6 kind 00 ignored", status, 32'h0000_5808);
        step(16'h8000, 2'd0);
        check("R6 gc clear", status, 32'h0000_1800);
        gc_step(2'b11, 16'h8000);
        check("R12 gc set wins", status, 32'h0000_7808);
        step(16'h8000, 2'd0);

        // R7 general call reset
        step(16'h02D0, 2'd0);
        check("R7 before", {22'h0, status[9:0]}, 32'h2D0);
        gc_step(2'b01, 16'h0000);
        check("R7 reset kind 01", status, 32'h0000_2008);
        step(16'h0008, 2'd2);
        check("R7 tracker idle", {20'h0, status[11:0]}, 32'h008);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule